// File: doc/BRIEF.md
# FSK Low-Pass Energy Demodulator

This block recovers bytes from a sampled two-tone frequency-shift-keyed line. Each line sample arrives with a one-cycle strobe. The sample passes through a first-order recursive low-pass stage. That stage keeps most of the low (200 Hz, logic 0) tone and strongly attenuates the high (600 Hz, logic 1) tone. A slicer then marks every filtered sample that rises above a fixed level. A framing counter uses these marks to find a start bit, time out each bit period, and decide each data bit from how many marked samples fall inside a guarded middle window of the bit.

The line idles on the high tone. A frame is one start bit on the low tone, followed by eight data bits sent least significant bit first. When the last data bit has been decided, the assembled byte is presented with a single-cycle valid pulse. A busy flag shows that a frame is being timed. Sample timing is 100 µs per strobe and 500 samples per bit. These values, the window limits and the thresholds are all parameters.

Top module: `fsk_lp_demod`

## Requirements
- R1: After a synchronous active-high reset, `busy` and `byte_valid` are both 0.
- R2: The filter computes y = 0.1116·x + 0.8884·y_prev with Q15 coefficients that sum to exactly 1.0. It therefore has unity gain at DC, and its internal state never exceeds full scale (4095 in the 27-bit accumulator's integer part).
- R3: A sample counts as a hit when the filtered value is strictly above 2866, which is 3.5/5 of full scale 4095. A steady line of 2800 never starts a frame. A steady line of 2950 does start one.
- R4: While idle, a start is declared only on two consecutive hit samples. A single-sample spike that produces one hit leaves `busy` at 0.
- R5: Each data bit is 0 when more than 20 hits fall in samples 101 to 400 of that bit, and 1 otherwise. Bits fill the byte from bit 0 (the first bit received) to bit 7. The start bit is not part of the byte.
- R6: Samples 1 to 100 and 401 to 500 of a bit do not affect its value. Low tone confined to those regions still decodes as 1.
- R7: `byte_valid` is high for exactly one clock, at the decision of the eighth data bit, while `busy` is still 1. It is never asserted at any other time.
- R8: `busy` rises on the second start hit and falls after the 500th sample of the eighth data bit. The receiver then accepts a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | One-cycle strobe marking a new line sample |
| sample_in | input | 12 | Unsigned line sample, 0 to 4095 spanning 0 to 5 V |
| byte_out | output | 8 | Last received byte, bit 0 received first |
| byte_valid | output | 1 | One-cycle pulse when `byte_out` is updated |
| busy | output | 1 | High while a frame is being timed |

## Verification
Faults in the bit-period counter or the window bounds show up as a changed byte value, or as a shifted `busy` falling edge, within one frame of about 4500 samples. A fault in the start qualifier shows up as `busy` rising on a lone spike, or as a frame with every bit shifted by one position. Filter coefficient or rounding errors move the steady-level threshold. The 2800 and 2950 plateaus expose such errors within a few dozen samples. Every byte is compared in order against a queue of expected values, so lost, extra or reordered bytes are all reported.

// File: rtl/fskd_pkg.sv
package fskd_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic valid;
        logic hit;
    } slice_t;

    function automatic int q_coef(real value, int frac_bits);
        return int'(value * (2.0 ** frac_bits));
    endfunction

    function automatic int scale_level(int level_mv, int full_mv, int full_code);
        return (level_mv * full_code) / full_mv;
    endfunction

endpackage

// File: rtl/fskd_lpf.sv
module fskd_lpf #(
    parameter int SAMPLE_W = 12,
    parameter int FRAC_W   = 15,
    parameter int COEF_A   = 3657,
    parameter int COEF_B   = 29111
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_x,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] y_out
);
    localparam int ACC_W = SAMPLE_W + FRAC_W;
    localparam int CW    = FRAC_W + 1;
    localparam int PW    = ACC_W + CW;
    localparam logic [ACC_W-1:0] CA      = ACC_W'(COEF_A);
    localparam logic [PW-1:0]    CB      = PW'(COEF_B);
    localparam logic [PW-1:0]    RND     = PW'(1) << (FRAC_W - 1);
    localparam logic [ACC_W-1:0] ACC_MAX = {{SAMPLE_W{1'b1}}, {FRAC_W{1'b0}}};

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;
    logic [ACC_W-1:0] in_term;
    logic [PW-1:0]    fb_prod;

    always_comb begin
        in_term  = ACC_W'(in_x) * CA;
        fb_prod  = PW'(acc_q) * CB;
        acc_next = in_term + ACC_W'((fb_prod + RND) >> FRAC_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_q <= acc_next;
            end
        end
    end

    assign y_out = acc_q[ACC_W-1:FRAC_W];

    // R2: accumulator never passes full scale
    a_r2_acc_bounded: assert property (@(posedge clk) disable iff (rst)
        acc_q <= ACC_MAX);

endmodule

// File: rtl/fskd_slicer.sv
module fskd_slicer
    import fskd_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int THRESH   = 2866
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] y_in,
    output slice_t              slice_o
);
    localparam logic [SAMPLE_W-1:0] LEVEL = SAMPLE_W'(THRESH);

    always_ff @(posedge clk) begin
        if (rst) begin
            slice_o <= '0;
        end else begin
            slice_o.valid <= in_valid;
            slice_o.hit   <= in_valid && (y_in > LEVEL);
        end
    end

endmodule

// File: rtl/fskd_framer.sv
module fskd_framer
    import fskd_pkg::*;
#(
    parameter int SAMPLES_PER_BIT = 500,
    parameter int GUARD_SAMPLES   = 100,
    parameter int DECIDE_SAMPLE   = 400,
    parameter int MIN_LOW_HITS    = 20,
    parameter int START_HITS      = 2,
    parameter int DATA_BITS       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  slice_t               slice_i,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 byte_valid_o,
    output logic                 busy_o
);
    localparam int IDX_W = $clog2(SAMPLES_PER_BIT + 1);
    localparam int RUN_W = $clog2(START_HITS + 1);
    localparam int LOW_W = $clog2(DECIDE_SAMPLE - GUARD_SAMPLES + 2);
    localparam int BIT_W = $clog2(DATA_BITS + 1);

    localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(SAMPLES_PER_BIT);
    localparam logic [IDX_W-1:0] IDX_GUARD  = IDX_W'(GUARD_SAMPLES);
    localparam logic [IDX_W-1:0] IDX_DECIDE = IDX_W'(DECIDE_SAMPLE);
    localparam logic [IDX_W-1:0] IDX_ENTRY  = IDX_W'(START_HITS);
    localparam logic [RUN_W-1:0] RUN_LAST   = RUN_W'(START_HITS - 1);
    localparam logic [LOW_W-1:0] LOW_MIN    = LOW_W'(MIN_LOW_HITS);
    localparam logic [BIT_W-1:0] BIT_LAST   = BIT_W'(DATA_BITS - 1);
    localparam logic [BIT_W-1:0] BIT_FULL   = BIT_W'(DATA_BITS);

    rx_state_e            state_q;
    logic [IDX_W-1:0]     idx_q;
    logic [RUN_W-1:0]     run_q;
    logic [LOW_W-1:0]     low_q;
    logic [BIT_W-1:0]     bits_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 done_q;

    logic [IDX_W-1:0]     idx_next;
    logic                 in_window;
    logic [LOW_W-1:0]     low_now;
    logic [LOW_W-1:0]     low_next;
    logic                 decide;
    logic                 bit_val;
    logic [DATA_BITS-1:0] shift_in;

    always_comb begin
        idx_next  = (idx_q == IDX_LAST) ? IDX_W'(1) : idx_q + IDX_W'(1);
        in_window = (idx_next > IDX_GUARD) && (idx_next <= IDX_DECIDE);
        low_now   = low_q + LOW_W'(in_window && slice_i.hit);
        low_next  = (idx_next == IDX_W'(1)) ? '0 : low_now;
        decide    = (state_q == RX_DATA) && (idx_next == IDX_DECIDE);
        bit_val   = !(low_now > LOW_MIN);
        shift_in  = {bit_val, shreg_q[DATA_BITS-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= RX_IDLE;
            idx_q        <= '0;
            run_q        <= '0;
            low_q        <= '0;
            bits_q       <= '0;
            shreg_q      <= '0;
            done_q       <= 1'b0;
            byte_o       <= '0;
            byte_valid_o <= 1'b0;
        end else begin
            byte_valid_o <= 1'b0;
            if (slice_i.valid) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (slice_i.hit) begin
                            if (run_q == RUN_LAST) begin
                                state_q <= RX_START;
                                idx_q   <= IDX_ENTRY;
                                run_q   <= '0;
                            end else begin
                                run_q <= run_q + RUN_W'(1);
                            end
                        end else begin
                            run_q <= '0;
                        end
                    end
                    RX_START: begin
                        idx_q <= idx_next;
                        if (idx_q == IDX_LAST) begin
                            state_q <= RX_DATA;
                            low_q   <= '0;
                            bits_q  <= '0;
                            done_q  <= 1'b0;
                        end
                    end
                    RX_DATA: begin
                        if ((idx_q == IDX_LAST) && done_q) begin
                            state_q <= RX_IDLE;
                            idx_q   <= '0;
                            low_q   <= '0;
                        end else begin
                            idx_q <= idx_next;
                            low_q <= low_next;
                            if (decide) begin
                                shreg_q <= shift_in;
                                bits_q  <= bits_q + BIT_W'(1);
                                if (bits_q == BIT_LAST) begin
                                    byte_o       <= shift_in;
                                    byte_valid_o <= 1'b1;
                                    done_q       <= 1'b1;
                                end
                            end
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    assign busy_o = (state_q != RX_IDLE);

    // R7: single-cycle pulse, always inside a frame
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |=> !byte_valid_o);
    a_r7_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> busy_o);
    // R5: a byte is released only once all data bits are decided
    a_r5_full_byte: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> (bits_q == BIT_FULL));
    // R8: sample index stays inside one bit period while framing
    a_r8_idx_range: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ((idx_q >= IDX_W'(1)) && (idx_q <= IDX_LAST)));

endmodule

// File: rtl/fsk_lp_demod.sv
module fsk_lp_demod
    import fskd_pkg::*;
#(
    parameter int SAMPLE_W        = 12,
    parameter int FRAC_W          = 15,
    parameter int THRESH_MV       = 3500,
    parameter int FULL_MV         = 5000,
    parameter int SAMPLES_PER_BIT = 500,
    parameter int GUARD_SAMPLES   = 100,
    parameter int DECIDE_SAMPLE   = 400,
    parameter int MIN_LOW_HITS    = 20,
    parameter int START_HITS      = 2,
    parameter int DATA_BITS       = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_valid,
    input  logic [SAMPLE_W-1:0]  sample_in,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 byte_valid,
    output logic                 busy
);
    localparam int COEF_A = q_coef(0.1116, FRAC_W);
    localparam int COEF_B = (1 << FRAC_W) - COEF_A;
    localparam int THRESH = scale_level(THRESH_MV, FULL_MV, (1 << SAMPLE_W) - 1);

    logic                filt_valid;
    logic [SAMPLE_W-1:0] filt_y;
    slice_t              slice;

    fskd_lpf #(
        .SAMPLE_W (SAMPLE_W),
        .FRAC_W   (FRAC_W),
        .COEF_A   (COEF_A),
        .COEF_B   (COEF_B)
    ) u_lpf (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sample_valid),
        .in_x      (sample_in),
        .out_valid (filt_valid),
        .y_out     (filt_y)
    );

    fskd_slicer #(
        .SAMPLE_W (SAMPLE_W),
        .THRESH   (THRESH)
    ) u_slicer (
        .clk      (clk),
        .rst      (rst),
        .in_valid (filt_valid),
        .y_in     (filt_y),
        .slice_o  (slice)
    );

    fskd_framer #(
        .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
        .GUARD_SAMPLES   (GUARD_SAMPLES),
        .DECIDE_SAMPLE   (DECIDE_SAMPLE),
        .MIN_LOW_HITS    (MIN_LOW_HITS),
        .START_HITS      (START_HITS),
        .DATA_BITS       (DATA_BITS)
    ) u_framer (
        .clk          (clk),
        .rst          (rst),
        .slice_i      (slice),
        .byte_o       (byte_out),
        .byte_valid_o (byte_valid),
        .busy_o       (busy)
    );

    // R4: a frame can only open on a sample the slicer marked as a hit
    a_r4_start_on_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(slice.hit));

endmodule

// File: tb/fsk_lp_demod_tb.sv
module fsk_lp_demod_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_valid = 1'b0;
    logic [11:0] sample_in = '0;
    logic [7:0] byte_out;
    logic       byte_valid;
    logic       busy;

    int checks = 0;
    int errors = 0;
    int received = 0;
    bit finished = 1'b0;
    bit prev_valid = 1'b0;
    logic [7:0] exp_q[$];
    real phase = 0.0;
    localparam real PI = 3.14159265358979;

    always #5 clk = ~clk;

    fsk_lp_demod u_dut (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_in    (sample_in),
        .byte_out     (byte_out),
        .byte_valid   (byte_valid),
        .busy         (busy)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put_sample(int v);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in    = 12'(v);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic put_level(int v, int n);
        for (int i = 0; i < n; i++) put_sample(v);
    endtask

    task automatic put_tone(bit b, int n);
        real step;
        step = 2.0 * PI * (b ? 600.0 : 200.0) * 1.0e-4;
        for (int i = 0; i < n; i++) begin
            int v;
            v = int'(2047.5 + 2047.5 * $sin(phase));
            if (v < 0) v = 0;
            if (v > 4095) v = 4095;
            put_sample(v);
            phase = phase + step;
        end
    endtask

    // Driver: one frame; guarded ones place low tone only in ignored regions
    task automatic send_frame(logic [7:0] d, bit guarded);
        exp_q.push_back(d);
        put_tone(1'b0, 250);
        chk(busy == 1'b1, "R8", "busy during start bit", busy, 1);
        put_tone(1'b0, 250);
        for (int i = 0; i < 8; i++) begin
            if (d[i] && guarded) begin
                put_tone(1'b0, 60);
                put_tone(1'b1, 410);
                put_tone(1'b0, 30);
            end else begin
                put_tone(d[i], 500);
            end
        end
        put_tone(1'b1, 300);
        chk(busy == 1'b0, "R8", "busy after frame", busy, 0);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_valid) begin
                chk(byte_valid == 1'b0, "R7", "valid pulse width", byte_valid, 0);
            end
            if (byte_valid) begin
                received++;
                chk(busy == 1'b1, "R7", "busy at valid", busy, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected byte", byte_out, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_out == e, "R5", "byte value", byte_out, e);
                end
            end
            prev_valid = byte_valid;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(byte_valid == 1'b0, "R1", "valid after reset", byte_valid, 0);

        // R3 / R2: steady level below threshold settles at input, no start
        put_level(2800, 600);
        chk(busy == 1'b0, "R3", "steady 2800 no start", busy, 0);

        // R4: one spike sample gives a single hit
        put_sample(4095);
        put_sample(2000);
        put_level(2800, 300);
        chk(busy == 1'b0, "R4", "single spike rejected", busy, 0);

        // R3: steady level above threshold opens a frame of all zeros
        exp_q.push_back(8'h00);
        put_level(2950, 20);
        chk(busy == 1'b1, "R3", "steady 2950 starts", busy, 1);
        put_level(2950, 4460);
        put_level(0, 100);
        put_tone(1'b1, 200);
        chk(busy == 1'b0, "R8", "idle after level frame", busy, 0);

        // R5 / R8: tone frames back to back
        send_frame(8'hA5, 1'b0);
        send_frame(8'hFF, 1'b0);
        send_frame(8'h5A, 1'b0);
        send_frame(8'h01, 1'b0);
        send_frame(8'h80, 1'b0);
        // R6: low tone only in guard regions of one bits
        send_frame(8'h81, 1'b1);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "all bytes delivered", exp_q.size(), 0);
        chk(received == 7, "R7", "valid pulse count", received, 7);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule